// File: doc/BRIEF.md
# Display Line Interrupt Controller

This block raises an interrupt when the display scan reaches a line chosen by software. It counts lines itself. A vertical-sync strobe from the display timing logic restarts the count at zero, and each horizontal-sync strobe advances it by one. When the counter takes on the programmed line number, the block sets a sticky status flag. The flag sets whether or not the interrupt is enabled.

One 32-bit control/status word is reached through a simple synchronous register port with address, write enable, write data and combinational read data. The word holds the target line, the interrupt enable and the status flag. Software clears the flag by writing 0 to its bit. Writing 1 to that bit does nothing. The interrupt output is a level: it is the status flag gated by the enable bit.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset the target line, enable and status flag are all 0, `irq` is low and a read of the register returns 0.
- R2: The register answers only at address `REG_ADDR` (0 by default). A read at any other address returns 0, and a write there changes nothing.
- R3: Bits [20 +: LINE_W] hold the target line number (29:20 when LINE_W is 10). The field is readable and writable.
- R4: Bit 16 is the interrupt enable (1 = allow `irq`). It is readable and writable.
- R5: Bit 0 is the status flag. Every other bit outside the target and enable fields is reserved: it reads as 0, and writing it has no effect.
- R6: The line counter loads 0 on a `vsync` strobe and adds 1 on an `hsync` strobe. `vsync` wins when both strobes arrive in the same cycle. The counter stops at 2^LINE_W−1, and further `hsync` strobes leave it there.
- R7: The flag sets at the clock edge where the counter loads a value equal to the target, including a `vsync` load of 0 when the target is 0. This happens whatever the enable bit holds. Once saturated, the counter produces no further matches.
- R8: Once set, the flag stays at 1. A register write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged.
- R9: When a match and a clearing write occur in the same cycle, the flag ends at 1.
- R10: `irq` is high exactly while both the flag and the enable bit are 1. It follows the register state with no added delay, so setting the enable while the flag is 1 raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hsync | input | 1 | One-cycle horizontal-sync strobe |
| vsync | input | 1 | One-cycle vertical-sync strobe |
| addr | input | ADDR_W | Register address |
| we | input | 1 | Register write enable |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Line interrupt level |

## Verification
The bench builds the block with LINE_W = 4 and ADDR_W = 2. With these values the counter saturates after 15 strobes. That makes it practical to sweep every target value from 0 to 15, with the enable bit alternating, and to follow each line step all the way into saturation. The narrow field also leaves bits 29:24 reserved, so the read-back mask is checked over a wider reserved area. The second address exercises the decode.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int REG_W    = 32;
  localparam int TGT_LSB  = 20;
  localparam int EN_BIT   = 16;
  localparam int STAT_BIT = 0;
endpackage

// File: rtl/lic_rst_sync.sv
module lic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lic_line_counter.sv
module lic_line_counter #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  output logic [LINE_W-1:0] cnt_q,
  output logic [LINE_W-1:0] cnt_d,
  output logic              load
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  always_comb begin
    cnt_d = cnt_q;
    load  = 1'b0;
    if (vsync) begin
      cnt_d = '0;
      load  = 1'b1;
    end else if (hsync && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
      load  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lic_match.sv
module lic_match #(
  parameter int LINE_W = 10
) (
  input  logic              load,
  input  logic [LINE_W-1:0] cnt_d,
  input  logic [LINE_W-1:0] target,
  output logic              match
);
  always_comb match = load && (cnt_d == target);
endmodule

// File: rtl/lic_ctrl_reg.sv
module lic_ctrl_reg
  import lic_pkg::*;
#(
  parameter int              LINE_W   = 10,
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              match,
  output logic [LINE_W-1:0] tgt_q,
  output logic              en_q,
  output logic              flag_q,
  output logic [REG_W-1:0]  rdata
);
  logic              hit;
  logic              wr_sel;
  logic [LINE_W-1:0] tgt_d;
  logic              en_d;
  logic              flag_d;
  logic              cfg_en;

  assign hit    = (addr == REG_ADDR);
  assign wr_sel = we && hit;
  assign cfg_en = wr_sel;

  always_comb begin
    tgt_d = wdata[TGT_LSB +: LINE_W];
    en_d  = wdata[EN_BIT];
  end

  always_comb begin
    flag_d = flag_q;
    if (match)                          flag_d = 1'b1;
    else if (wr_sel && !wdata[STAT_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      en_q  <= 1'b0;
    end else if (cfg_en) begin
      tgt_q <= tgt_d;
      en_q  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[TGT_LSB +: LINE_W] = tgt_q;
      rdata[EN_BIT]            = en_q;
      rdata[STAT_BIT]          = flag_q;
    end
  end
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import lic_pkg::*;
#(
  parameter int                LINE_W   = 10,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic              rst_sync_n;
  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W-1:0] cnt_d;
  logic              load;
  logic              match;
  logic [LINE_W-1:0] tgt_q;
  logic              en_q;
  logic              flag_q;

  initial begin
    if (LINE_W < 1 || LINE_W > 10)
      $error("LINE_W must lie in 1..10");
  end

  lic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lic_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hsync (hsync),
    .vsync (vsync),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d),
    .load  (load)
  );

  lic_match #(.LINE_W(LINE_W)) u_match (
    .load   (load),
    .cnt_d  (cnt_d),
    .target (tgt_q),
    .match  (match)
  );

  lic_ctrl_reg #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (addr),
    .we     (we),
    .wdata  (wdata),
    .match  (match),
    .tgt_q  (tgt_q),
    .en_q   (en_q),
    .flag_q (flag_q),
    .rdata  (rdata)
  );

  assign irq = flag_q & en_q;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int                LINE_W   = 10,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync,
  input logic              vsync,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic [LINE_W-1:0] cnt,
  input logic              flag,
  input logic [LINE_W-1:0] tgt,
  input logic              en
);
  localparam logic [LINE_W-1:0] CMAX = {LINE_W{1'b1}};
  localparam logic [31:0] LIVE = (32'((64'd1 << LINE_W) - 1) << 20) | 32'h0001_0001;

  logic clr_wr;
  assign clr_wr = we && (addr == REG_ADDR) && !wdata[0];

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (cnt == '0));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !vsync && cnt != CMAX) |=> (cnt == LINE_W'($past(cnt) + 1'b1)));

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !vsync && cnt == CMAX) |=> (cnt == CMAX));

  // R7
  zero_line_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && tgt == '0) |=> flag);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hsync && !vsync) |=> !flag);

  // R9
  match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !vsync && cnt != CMAX && LINE_W'(cnt + 1'b1) == tgt) |=> flag);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~LIVE) == 32'h0));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == (flag && en)));
endmodule

bind line_irq_ctrl lic_checker #(
  .LINE_W(LINE_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .hsync (hsync),
  .vsync (vsync),
  .addr  (addr),
  .we    (we),
  .wdata (wdata),
  .rdata (rdata),
  .irq   (irq),
  .cnt   (cnt_q),
  .flag  (flag_q),
  .tgt   (tgt_q),
  .en    (en_q)
);

// File: tb/line_irq_ctrl_bench.sv
`timescale 1ns/1ps
module line_irq_ctrl_bench;
  localparam int LW  = 4;
  localparam int AW  = 2;
  localparam int MAXC = (1 << LW) - 1;

  logic          clk;
  logic          rst_n;
  logic          hsync;
  logic          vsync;
  logic [AW-1:0] addr;
  logic          we;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk;
  int n_fail;
  int m_cnt;
  int m_tgt;
  int m_en;
  int m_flag;

  line_irq_ctrl #(.LINE_W(LW), .ADDR_W(AW), .REG_ADDR('0)) u_line_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .addr(addr), .we(we), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return 32'((m_tgt << 20) + (m_en << 16) + m_flag);
  endfunction

  task automatic cyc(input logic hs, input logic vs, input logic w,
                     input logic [AW-1:0] a, input logic [31:0] d);
    int match;
    int ld;
    int nxt;
    @(negedge clk);
    hsync = hs; vsync = vs; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    hsync = 1'b0; vsync = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    ld = 0; nxt = m_cnt;
    if (vs) begin ld = 1; nxt = 0; end
    else if (hs && m_cnt != MAXC) begin ld = 1; nxt = m_cnt + 1; end
    match = (ld != 0) && (nxt == m_tgt);
    if (match) m_flag = 1;
    else if (w && a == 0 && !d[0]) m_flag = 0;
    if (w && a == 0) begin
      m_tgt = int'(d[20 +: LW]);
      m_en  = int'(d[16]);
    end
    m_cnt = nxt;
  endtask

  task automatic state(input string tag);
    addr = '0;
    #0.1;
    check({tag, " reg"}, rdata, exp_word());
    check({tag, " irq"}, {31'b0, irq}, (m_flag != 0 && m_en != 0) ? 32'd1 : 32'd0);
  endtask

  function automatic logic [31:0] cfg(input int t, input int e, input int f);
    return 32'((t << 20) + (e << 16) + f);
  endfunction

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_cnt = 0; m_tgt = 0; m_en = 0; m_flag = 0;
    hsync = 0; vsync = 0; we = 0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    state("R1 reset");

    // R5: reserved bits ignored; target and enable take their bits
    cyc(0, 0, 1, 2'd0, 32'hFFFF_FFFE);
    state("R5 mask");
    check("R3 target field", {28'b0, rdata[23:20]}, 32'd15);
    check("R4 enable bit", {31'b0, rdata[16]}, 32'd1);

    // R2: other address
    cyc(0, 0, 1, 2'd1, 32'h0);
    state("R2 foreign write");
    addr = 2'd1;
    #0.1;
    check("R2 foreign read", rdata, 32'h0);
    addr = '0;

    // R6 R7 R10 sweep of every target, enable alternating
    for (int t = 0; t <= MAXC; t++) begin
      cyc(0, 0, 1, 2'd0, cfg(t, t % 2, 0));
      cyc(0, 1, 0, 2'd0, 32'h0);
      state("R7 vsync load");
      cyc(0, 0, 1, 2'd0, cfg(t, t % 2, 0));
      for (int s = 0; s < MAXC + 3; s++) begin
        cyc(1, 0, 0, 2'd0, 32'h0);
        state("R7 line step");
      end
      cyc(0, 0, 1, 2'd0, cfg(t, t % 2, 0));
      for (int s = 0; s < 3; s++) begin
        cyc(1, 0, 0, 2'd0, 32'h0);
        state("R7 saturated");
      end
    end

    // R6: vsync wins over hsync
    cyc(0, 0, 1, 2'd0, cfg(1, 0, 0));
    cyc(1, 1, 0, 2'd0, 32'h0);
    state("R6 vsync priority");
    cyc(1, 0, 0, 2'd0, 32'h0);
    state("R6 step after restart");

    // R8: write 1 leaves flag set; write 0 clears
    cyc(0, 0, 1, 2'd0, cfg(1, 0, 1));
    state("R8 write one");
    cyc(0, 0, 1, 2'd0, cfg(1, 0, 0));
    state("R8 write zero");
    cyc(0, 0, 1, 2'd0, cfg(1, 0, 1));
    state("R8 write one on clear flag");

    // R9: match and clear in same cycle
    cyc(0, 1, 0, 2'd0, 32'h0);
    cyc(1, 0, 1, 2'd0, cfg(1, 0, 0));
    state("R9 collision");
    check("R9 flag", {31'b0, rdata[0]}, 32'd1);

    // R10: enabling with flag set raises irq
    cyc(0, 0, 1, 2'd0, cfg(1, 1, 1));
    state("R10 enable late");
    check("R10 irq high", {31'b0, irq}, 32'd1);
    cyc(0, 0, 1, 2'd0, cfg(1, 1, 0));
    state("R10 cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule